// File: doc/BRIEF.md
# Core Power-Domain Reset Sequencer

This block sits in the slow-clock domain next to a core supply. It keeps three active-low resets, for the core supply domain, the processor and the peripherals, asserted until the core supply can be trusted. It then releases them one after another with fixed slow-clock gaps. Before the core reset can be released, a start-up interval has to run out and a brownout-OK indication has to be seen stable for a full slow-clock cycle.

After release, the resets can be pulled down again by three conditions. The regulator enable request may be withdrawn, which happens before the supply is turned off. A supply-monitor detection may occur while its reset enable is set, or the brownout-OK input may fall while its reset enable is set. Each of these conditions asserts all three resets through a combinational path, so no clock edge is needed. A two-flop synchronised copy of the condition keeps the resets down for at least the following edges and restarts the whole count sequence from the beginning. A detection whose enable bit is clear has no effect.

Top module: `core_rst_seq`

## Requirements
- R1: While `rst_n` is low, all three reset outputs are driven low (asserted).
- R2: The core reset is released only after the synchronised brownout-OK input has been sampled high on two consecutive clock edges. A high level on `bod_ok_i` that is seen by only one edge never releases it.
- R3: After `rst_n` rises (or `reg_en_i` rises after being low), with brownout-OK already stable, the core reset goes high after the 11th rising edge. This is 2 edges of synchronisation, 1 idle edge, 7 start-up edges and 1 release edge.
- R4: The processor reset is released exactly 3 edges after the core reset, and the peripheral reset exactly 2 edges (the `EXT_HOLD` parameter) after the processor reset. No reset is ever high while the one before it in this order is low.
- R5: When `smon_rst_en_i`=1, a high `smon_det_i` drives all three outputs low at once, without waiting for a clock edge.
- R6: A forcing condition that is sampled by an edge keeps the core reset low on the next edge. The sequence then restarts: for a detect pulse seen by exactly one edge, the core reset is released after the 12th edge, counting that edge as the first.
- R7: With `smon_rst_en_i`=0, supply-monitor pulses leave all outputs unchanged. With `bod_rst_en_i`=0, a low `bod_ok_i` after release leaves all outputs unchanged.
- R8: When `bod_rst_en_i`=1, a low `bod_ok_i` drives all three outputs low at once and restarts the sequence.
- R9: A low `reg_en_i` drives all three outputs low at once and holds them low for as long as it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en_i | input | 1 | Regulator enable request; low means the core supply is being shut down |
| bod_ok_i | input | 1 | Core brownout-OK (asynchronous), high when the supply is regulated |
| smon_det_i | input | 1 | Supply-monitor detection (asynchronous) |
| smon_rst_en_i | input | 1 | Enables reset on supply-monitor detection |
| bod_rst_en_i | input | 1 | Enables reset on brownout |
| core_rst_n_o | output | 1 | Core supply domain reset, active low |
| cpu_rst_n_o | output | 1 | Processor reset, active low |
| periph_rst_n_o | output | 1 | Peripheral reset, active low |

## Verification
The assertions assume that the asynchronous inputs (`reg_en_i`, `bod_ok_i`, `smon_det_i` and the two enables) are stable at each rising edge. In particular, a forcing pulse must last long enough to be sampled by at least one edge, so that the synchronised hold can take over from the combinational path. The bench changes every input one time unit after a falling edge and samples outputs at falling edges, or shortly after such a change for the combinational checks. Every forcing pulse it applies spans at least one rising edge.

// File: rtl/rsq_pkg.sv
// Package: shared sequencer state type for the core reset sequencer.
// Assumes: nothing; types only.
package rsq_pkg;
    typedef enum logic [2:0] {
        SQ_OFF,      // all held, waiting for a clean start
        SQ_START,    // start-up interval running
        SQ_WAIT_BOD, // waiting for qualified brownout-OK
        SQ_CORE,     // core released, processor gap running
        SQ_CPU,      // processor released, peripheral gap running
        SQ_RUN       // everything released
    } seq_state_t;
endpackage

// File: rtl/rsq_sync.sv
// Module: multi-stage synchroniser with a selectable reset value.
// Assumes: d is asynchronous to clk; STAGES >= 2. All stages are visible
// so that a caller can OR them into a hold term.
module rsq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d,
    output logic [STAGES-1:0] q
);
    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= {STAGES{RST_VAL}};
        end else begin
            q <= {q[STAGES-2:0], d};
        end
    end
endmodule

// File: rtl/rsq_bod_qual.sv
// Module: brownout-OK qualifier. Synchronises the input, then declares it
// valid only once it has been seen high on two consecutive edges.
// Assumes: bod_ok is asynchronous; a reset means "not OK".
module rsq_bod_qual #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bod_ok,
    output logic bod_valid
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    rsq_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bod_ok),
        .q     (sync_q)
    );

    // Remember the previous synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[STAGES-1];
        end
    end

    // Valid when two consecutive synchronised samples were high.
    assign bod_valid = sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/rsq_fsm.sv
// Module: release sequencer. Walks start-up, brownout wait, and the two
// staged release gaps; any synchronised force returns it to the start.
// Assumes: force_s and bod_valid are already synchronous to clk.
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int STARTUP  = 7,
    parameter int CPU_GAP  = 3,
    parameter int EXT_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_s,
    input  logic bod_valid,
    output logic core_rel,
    output logic cpu_rel,
    output logic periph_rel
);
    localparam int MAXC  = (STARTUP > CPU_GAP) ?
                           ((STARTUP > EXT_HOLD) ? STARTUP : EXT_HOLD) :
                           ((CPU_GAP > EXT_HOLD) ? CPU_GAP : EXT_HOLD);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] START_END = CNT_W'(STARTUP - 1);
    localparam logic [CNT_W-1:0] CPU_END   = CNT_W'(CPU_GAP - 1);
    localparam logic [CNT_W-1:0] EXT_END   = CNT_W'(EXT_HOLD - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Advance the release sequence, restarting on any forced reset.
    always_ff @(posedge clk) begin
        if (!rst_n || force_s) begin
            state <= SQ_OFF;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_OFF: begin
                    state <= SQ_START;
                    cnt   <= '0;
                end
                SQ_START: begin
                    if (cnt == START_END) begin
                        state <= SQ_WAIT_BOD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_WAIT_BOD: begin
                    if (bod_valid) begin
                        state <= SQ_CORE;
                        cnt   <= '0;
                    end
                end
                SQ_CORE: begin
                    if (cnt == CPU_END) begin
                        state <= SQ_CPU;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_CPU: begin
                    if (cnt == EXT_END) begin
                        state <= SQ_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SQ_RUN;
                end
            endcase
        end
    end

    // Decode which stages are released in the current state.
    always_comb begin
        core_rel   = (state == SQ_CORE) || (state == SQ_CPU) || (state == SQ_RUN);
        cpu_rel    = (state == SQ_CPU) || (state == SQ_RUN);
        periph_rel = (state == SQ_RUN);
    end
endmodule

// File: rtl/core_rst_seq.sv
// Module: core power-domain reset sequencer (top).
// Builds a combined force condition, asserts all resets from it at once,
// synchronises it to hold and restart the sequence, and gates the
// staged releases from the sequencer.
// Assumes: clk is the slow clock; forcing pulses span at least one edge.
module core_rst_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int STARTUP     = 7,
    parameter int CPU_GAP     = 3,
    parameter int EXT_HOLD    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_en_i,
    input  logic bod_ok_i,
    input  logic smon_det_i,
    input  logic smon_rst_en_i,
    input  logic bod_rst_en_i,
    output logic core_rst_n_o,
    output logic cpu_rst_n_o,
    output logic periph_rst_n_o
);
    logic                   force_raw;
    logic [SYNC_STAGES-1:0] force_q;
    logic                   hold;
    logic                   bod_valid;
    logic                   core_rel;
    logic                   cpu_rel;
    logic                   periph_rel;

    // Combine every enabled source that must pull the resets down.
    always_comb begin
        force_raw = !reg_en_i
                  || (smon_rst_en_i && smon_det_i)
                  || (bod_rst_en_i && !bod_ok_i);
    end

    rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_force_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (force_raw),
        .q     (force_q)
    );

    rsq_bod_qual #(.STAGES(SYNC_STAGES)) u_bod_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .bod_ok    (bod_ok_i),
        .bod_valid (bod_valid)
    );

    rsq_fsm #(
        .STARTUP  (STARTUP),
        .CPU_GAP  (CPU_GAP),
        .EXT_HOLD (EXT_HOLD)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_s    (force_q[SYNC_STAGES-1]),
        .bod_valid  (bod_valid),
        .core_rel   (core_rel),
        .cpu_rel    (cpu_rel),
        .periph_rel (periph_rel)
    );

    // Hold covers the raw condition and every synchroniser stage.
    always_comb begin
        hold           = force_raw || (|force_q);
        core_rst_n_o   = core_rel   && !hold;
        cpu_rst_n_o    = cpu_rel    && !hold;
        periph_rst_n_o = periph_rel && !hold;
    end
endmodule

// File: rtl/core_rst_seq_chk.sv
// Module: property checker for core_rst_seq, attached by bind.
// Assumes: inputs are stable at each rising clock edge.
module core_rst_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic reg_en_i,
    input logic bod_ok_i,
    input logic smon_det_i,
    input logic smon_rst_en_i,
    input logic bod_rst_en_i,
    input logic core_rst_n_o,
    input logic cpu_rst_n_o,
    input logic periph_rst_n_o
);
    logic forcing;
    // Forcing condition seen at the ports.
    assign forcing = !reg_en_i || (smon_rst_en_i && smon_det_i)
                   || (bod_rst_en_i && !bod_ok_i);

    // R4: processor never released while core is held.
    p_cpu_after_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n_o |-> core_rst_n_o);

    // R4: peripherals never released while processor is held.
    p_periph_after_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst_n_o |-> cpu_rst_n_o);

    // R4: processor release comes at least three edges after core release.
    p_cpu_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n_o) |-> $past(core_rst_n_o, 3));

    // R5, R8, R9: an enabled forcing condition holds every reset low.
    p_force_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
        forcing |-> (!core_rst_n_o && !cpu_rst_n_o && !periph_rst_n_o));

    // R6: a sampled forcing condition keeps core held on the next edge.
    p_force_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        forcing |=> !core_rst_n_o);
endmodule

bind core_rst_seq core_rst_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_en_i       (reg_en_i),
    .bod_ok_i       (bod_ok_i),
    .smon_det_i     (smon_det_i),
    .smon_rst_en_i  (smon_rst_en_i),
    .bod_rst_en_i   (bod_rst_en_i),
    .core_rst_n_o   (core_rst_n_o),
    .cpu_rst_n_o    (cpu_rst_n_o),
    .periph_rst_n_o (periph_rst_n_o)
);

// File: tb/core_rst_seq_bench.sv
// Directed bench for core_rst_seq: one task per scenario.
module core_rst_seq_bench;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_en = 1'b1;
    logic bod_ok = 1'b1;
    logic smon_det = 1'b0;
    logic smon_en = 1'b0;
    logic bod_en = 1'b0;
    logic core_n, cpu_n, periph_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    core_rst_seq u_core_rst_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_en_i       (reg_en),
        .bod_ok_i       (bod_ok),
        .smon_det_i     (smon_det),
        .smon_rst_en_i  (smon_en),
        .bod_rst_en_i   (bod_en),
        .core_rst_n_o   (core_n),
        .cpu_rst_n_o    (cpu_n),
        .periph_rst_n_o (periph_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int which);
        case (which)
            0:       return core_n;
            1:       return cpu_n;
            default: return periph_n;
        endcase
    endfunction

    // Count rising edges until the chosen output is high at a falling edge.
    task automatic count_until(input int which, input int start, output int n);
        n = start;
        for (int i = 0; i < 200; i++) begin
            if (pick(which)) break;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic all_states(input string req, input int exp);
        int v;
        v = {29'd0, core_n, cpu_n, periph_n};
        check(v == exp, req, v, exp);
    endtask

    // Count edges from a just-applied release to core, then processor, then peripherals.
    task automatic chain(input string req, input int first, input int start);
        int n;
        count_until(0, start, n);
        check(n == first, req, n, first);
        count_until(1, 0, n);
        check(n == 3, "R4 cpu gap", n, 3);
        count_until(2, 0, n);
        check(n == 2, "R4 periph gap", n, 2);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        all_states("R1 in reset", 0);
        rst_n = 1'b1;
        chain("R3 startup release", 11, 0);
    endtask

    task automatic t_disabled;
        @(negedge clk); #1;
        smon_en = 1'b0; smon_det = 1'b1;
        #1 all_states("R7 smon disabled now", 7);
        repeat (2) @(negedge clk);
        smon_det = 1'b0;
        repeat (4) @(negedge clk);
        all_states("R7 smon disabled later", 7);
        bod_en = 1'b0; bod_ok = 1'b0;
        repeat (5) @(negedge clk);
        all_states("R7 bod disabled", 7);
        bod_ok = 1'b1;
        repeat (5) @(negedge clk);
        all_states("R7 bod restored", 7);
    endtask

    task automatic t_smon;
        @(negedge clk); #1;
        smon_en = 1'b1; smon_det = 1'b1;
        #1 all_states("R5 immediate", 0);
        @(posedge clk);
        @(negedge clk);
        smon_det = 1'b0;
        check(core_n == 1'b0, "R6 held after edge", core_n, 0);
        chain("R6 restart", 12, 1);
        smon_en = 1'b0;
    endtask

    task automatic t_bod;
        @(negedge clk); #1;
        bod_en = 1'b1; bod_ok = 1'b0;
        #1 all_states("R8 immediate", 0);
        @(posedge clk);
        @(negedge clk);
        bod_ok = 1'b1;
        chain("R8 restart", 12, 1);
        bod_en = 1'b0;
    endtask

    task automatic t_reg;
        @(negedge clk); #1;
        reg_en = 1'b0;
        #1 all_states("R9 immediate", 0);
        repeat (6) @(negedge clk);
        all_states("R9 held", 0);
        reg_en = 1'b1;
        chain("R9 restart", 11, 0);
    endtask

    task automatic t_bod_gate;
        int n;
        bod_ok = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(core_n == 1'b0, "R2 held without bod", core_n, 0);
        bod_ok = 1'b1;
        @(negedge clk);
        bod_ok = 1'b0;
        repeat (10) @(negedge clk);
        check(core_n == 1'b0, "R2 single-edge glitch", core_n, 0);
        bod_ok = 1'b1;
        count_until(0, 0, n);
        check(n == 4, "R2 release after stable", n, 4);
        count_until(2, 0, n);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        t_reset();
        t_disabled();
        t_smon();
        t_bod();
        t_reg();
        t_bod_gate();
        finish_up();
    end
endmodule